// File: doc/BRIEF.md
# Floating-Point Control and Status Register

This block holds the 32-bit control/status word of a floating-point unit. It keeps a 2-bit rounding mode, five sticky exception flags, five exception enables, six cause bits and eight condition codes. Software reaches it through a control-register index: index 31 is the status word, and it can be read and written. Index 0 is a revision register that reads as zero. Every other index reads as zero and ignores writes.

The arithmetic datapath reports each finished operation with its exception set: inexact, underflow, overflow, divide-by-zero and invalid, plus an unimplemented-operation indication. A compare also carries a 1-bit result and a 3-bit condition-code index. The block rewrites the cause bits on every report and accumulates the flags. In the same cycle it tells the datapath whether the result write-back must be dropped. One cycle later it pulses a trap whenever a cause bit meets its enable. The exceptions themselves are computed elsewhere.

Field layout: rounding mode at bits 1:0. Flags at bits 6:2, enables at bits 11:7 and cause at bits 16:12, each ordered inexact, underflow, overflow, divide-by-zero, invalid from the low bit up. Unimplemented cause at bit 17. Condition code 0 at bit 23 and condition codes 1 to 7 at bits 25 to 31. Bits 18 to 22 and bit 24 are reserved and read as zero.

Top module: `fp_csr_unit`

## Requirements
- R1: After reset the status word is zero, `trap_o` and `wb_block_o` are low, and a read of index 31 returns zero.
- R2: A software write to index 31 stores the rounding mode in bits 1:0 (0 nearest, 1 toward zero, 2 toward +infinity, 3 toward -infinity), and the new value appears on `csr_o` and on `rd_data` one cycle later.
- R3: A software write to index 31 updates every non-reserved bit and leaves the reserved bits (18 to 22, 24) at zero. A write to any other index changes nothing.
- R4: Each reported operation overwrites all six cause bits (16:12 from the exception vector, 17 from the unimplemented indication) with that operation's exceptions, clearing causes it does not report.
- R5: Each reported exception sets its flag bit. Operations never clear a flag.
- R6: `trap_o` is high for one cycle after any update (software write or operation) whose resulting word has a cause bit in 16:12 together with the enable five positions lower, or has cause bit 17 set. Cause bit 17 traps regardless of the enables.
- R7: `wb_block_o` is high, in the same cycle as `op_valid`, exactly when that operation's update would raise a trap.
- R8: A non-trapping compare writes its result into the selected condition code (index 0 at bit 23, index k at bit 24+k for k = 1 to 7). A result of 1 sets the bit and a result of 0 clears it. Other condition codes are unchanged.
- R9: A compare whose update traps leaves all condition codes unchanged, while its cause and flag bits are still recorded.
- R10: A signaling compare that reports invalid records only the invalid cause and flag, even when other exceptions are reported with it.
- R11: Reading index 0 returns zero, reading any index other than 0 and 31 returns zero, and reading index 31 returns the status word.
- R12: When a software write to index 31 and an operation report arrive in the same cycle, the software write is applied, the operation is dropped, and `wb_block_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_wr_en | input | 1 | Software control-register write strobe |
| sw_wr_idx | input | 5 | Control-register index of the write |
| sw_wr_data | input | 32 | Write data |
| rd_idx | input | 5 | Control-register index to read |
| rd_data | output | 32 | Combinational read data |
| op_valid | input | 1 | An operation is reporting this cycle |
| op_exc | input | 5 | Exceptions: bit0 inexact, bit1 underflow, bit2 overflow, bit3 divide-by-zero, bit4 invalid |
| op_unimpl | input | 1 | Unimplemented-operation indication |
| op_is_cmp | input | 1 | The operation is a compare |
| op_cmp_signaling | input | 1 | The compare is of the signaling kind |
| op_cc_idx | input | 3 | Condition code targeted by the compare |
| op_cc_val | input | 1 | Compare result |
| csr_o | output | 32 | Current status word |
| trap_o | output | 1 | One-cycle trap pulse after a matching update |
| wb_block_o | output | 1 | Suppress the result write-back of the current operation |

## Verification
A corrupted cause field shows on `csr_o` one cycle after the operation. A dropped enable or a misplaced unimplemented bit shows through `trap_o` on the same edge, and through `wb_block_o` before the edge of the operation that should have trapped. A condition code at the wrong position, or one written during a trapping compare, shows on `csr_o` and on reads of index 31 from the next cycle. A flag cleared by mistake stays visible in bits 6:2 until the next software write.

// File: rtl/fpcsr_pkg.sv
package fpcsr_pkg;
    localparam int CSR_W      = 32;
    localparam int NUM_EXC    = 5;
    localparam int NUM_CC     = 8;
    localparam int IDX_W      = 5;
    localparam int CC_IDX_W   = $clog2(NUM_CC);
    localparam int FLAG_LSB   = 2;
    localparam int EN_LSB     = 7;
    localparam int CAUSE_LSB  = 12;
    localparam int UNIMPL_BIT = 17;
    localparam int CC0_BIT    = 23;
    localparam int CCN_BASE   = 24;
    localparam int EXC_INV    = 4;
    localparam logic [IDX_W-1:0] CSR_IDX = 5'd31;
    localparam logic [IDX_W-1:0] REV_IDX = 5'd0;
    localparam logic [CSR_W-1:0] REV_VALUE = '0;
    localparam logic [CSR_W-1:0] RSVD_MASK = 32'h017C_0000;

    typedef struct packed {
        logic [CSR_W-1:0] csr;
        logic             trap;
    } state_t;

    function automatic int cc_pos(input int i);
        return (i == 0) ? CC0_BIT : CCN_BASE + i;
    endfunction
endpackage

// File: rtl/fpcsr_cause_merge.sv
module fpcsr_cause_merge
    import fpcsr_pkg::*;
(
    input  logic [CSR_W-1:0]   csr_i,
    input  logic [NUM_EXC-1:0] exc_i,
    input  logic               unimpl_i,
    input  logic               sig_cmp_i,
    output logic [CSR_W-1:0]   csr_o
);
    logic [NUM_EXC-1:0] eff;
    logic               eff_unimpl;

    always_comb begin
        eff        = exc_i;
        eff_unimpl = unimpl_i;
        if (sig_cmp_i && exc_i[EXC_INV]) begin
            eff          = '0;
            eff[EXC_INV] = 1'b1;
            eff_unimpl   = 1'b0;
        end
        csr_o = csr_i;
        csr_o[CAUSE_LSB +: NUM_EXC] = eff;
        csr_o[UNIMPL_BIT]           = eff_unimpl;
        csr_o[FLAG_LSB +: NUM_EXC]  = csr_i[FLAG_LSB +: NUM_EXC] | eff;
    end
endmodule

// File: rtl/fpcsr_trap_detect.sv
module fpcsr_trap_detect
    import fpcsr_pkg::*;
(
    input  logic [NUM_EXC-1:0] cause_i,
    input  logic               unimpl_i,
    input  logic [NUM_EXC-1:0] enable_i,
    output logic               match_o
);
    always_comb begin
        match_o = (|(cause_i & enable_i)) | unimpl_i;
    end
endmodule

// File: rtl/fpcsr_cc_write.sv
module fpcsr_cc_write
    import fpcsr_pkg::*;
#(
    parameter int N = NUM_CC,
    localparam int IW = $clog2(N)
) (
    input  logic [CSR_W-1:0] csr_i,
    input  logic             en_i,
    input  logic [IW-1:0]    idx_i,
    input  logic             val_i,
    output logic [CSR_W-1:0] csr_o
);
    logic [N-1:0] hit;

    for (genvar g = 0; g < N; g++) begin : g_hit
        assign hit[g] = en_i && (idx_i == IW'(g));
    end

    always_comb begin
        csr_o = csr_i;
        for (int i = 0; i < N; i++) begin
            if (hit[i]) csr_o[cc_pos(i)] = val_i;
        end
    end
endmodule

// File: rtl/fp_csr_unit.sv
module fp_csr_unit
    import fpcsr_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sw_wr_en,
    input  logic [IDX_W-1:0]    sw_wr_idx,
    input  logic [CSR_W-1:0]    sw_wr_data,
    input  logic [IDX_W-1:0]    rd_idx,
    output logic [CSR_W-1:0]    rd_data,
    input  logic                op_valid,
    input  logic [NUM_EXC-1:0]  op_exc,
    input  logic                op_unimpl,
    input  logic                op_is_cmp,
    input  logic                op_cmp_signaling,
    input  logic [CC_IDX_W-1:0] op_cc_idx,
    input  logic                op_cc_val,
    output logic [CSR_W-1:0]    csr_o,
    output logic                trap_o,
    output logic                wb_block_o
);
    state_t           st_d, st_q;
    logic             sw_hit, op_go;
    logic [CSR_W-1:0] merged, cc_out, sw_val;
    logic             op_match, sw_match;

    assign sw_hit = sw_wr_en && (sw_wr_idx == CSR_IDX);
    assign op_go  = op_valid && !sw_hit;
    assign sw_val = (sw_wr_data & ~RSVD_MASK) | (st_q.csr & RSVD_MASK);

    fpcsr_cause_merge u_merge (
        .csr_i     (st_q.csr),
        .exc_i     (op_exc),
        .unimpl_i  (op_unimpl),
        .sig_cmp_i (op_is_cmp && op_cmp_signaling),
        .csr_o     (merged)
    );

    fpcsr_trap_detect u_op_trap (
        .cause_i  (merged[CAUSE_LSB +: NUM_EXC]),
        .unimpl_i (merged[UNIMPL_BIT]),
        .enable_i (merged[EN_LSB +: NUM_EXC]),
        .match_o  (op_match)
    );

    fpcsr_trap_detect u_sw_trap (
        .cause_i  (sw_val[CAUSE_LSB +: NUM_EXC]),
        .unimpl_i (sw_val[UNIMPL_BIT]),
        .enable_i (sw_val[EN_LSB +: NUM_EXC]),
        .match_o  (sw_match)
    );

    fpcsr_cc_write #(.N(NUM_CC)) u_cc (
        .csr_i (merged),
        .en_i  (op_go && op_is_cmp && !op_match),
        .idx_i (op_cc_idx),
        .val_i (op_cc_val),
        .csr_o (cc_out)
    );

    always_comb begin
        st_d      = st_q;
        st_d.trap = 1'b0;
        if (sw_hit) begin
            st_d.csr  = sw_val;
            st_d.trap = sw_match;
        end else if (op_valid) begin
            st_d.csr  = cc_out;
            st_d.trap = op_match;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        if (rd_idx == CSR_IDX)      rd_data = st_q.csr;
        else if (rd_idx == REV_IDX) rd_data = REV_VALUE;
        else                        rd_data = '0;
    end

    assign csr_o      = st_q.csr;
    assign trap_o     = st_q.trap;
    assign wb_block_o = op_go && op_match;
endmodule

// File: rtl/fpcsr_checker.sv
module fpcsr_checker
    import fpcsr_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             sw_wr_en,
    input logic [IDX_W-1:0] sw_wr_idx,
    input logic [IDX_W-1:0] rd_idx,
    input logic [CSR_W-1:0] rd_data,
    input logic             op_valid,
    input logic             op_is_cmp,
    input logic [CSR_W-1:0] csr_o,
    input logic             trap_o,
    input logic             wb_block_o
);
    assert_rsvd_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_o & RSVD_MASK) == '0);

    assert_flags_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !(sw_wr_en && sw_wr_idx == CSR_IDX))
        |=> (($past(csr_o[FLAG_LSB +: NUM_EXC]) & ~csr_o[FLAG_LSB +: NUM_EXC]) == '0));

    assert_trap_has_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |-> ((|(csr_o[CAUSE_LSB +: NUM_EXC] & csr_o[EN_LSB +: NUM_EXC])) || csr_o[UNIMPL_BIT]));

    assert_block_needs_op_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wb_block_o |-> op_valid);

    assert_cc_hold_on_trap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_is_cmp && wb_block_o) |=> $stable(csr_o[CSR_W-1:CC0_BIT]));

    assert_other_idx_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_idx != CSR_IDX) |-> (rd_data == '0));
endmodule

bind fp_csr_unit fpcsr_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sw_wr_en   (sw_wr_en),
    .sw_wr_idx  (sw_wr_idx),
    .rd_idx     (rd_idx),
    .rd_data    (rd_data),
    .op_valid   (op_valid),
    .op_is_cmp  (op_is_cmp),
    .csr_o      (csr_o),
    .trap_o     (trap_o),
    .wb_block_o (wb_block_o)
);

// File: tb/sim_fp_csr_unit.sv
module sim_fp_csr_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sw_wr_en = 1'b0;
    logic [4:0]  sw_wr_idx = '0;
    logic [31:0] sw_wr_data = '0;
    logic [4:0]  rd_idx = 5'd31;
    logic [31:0] rd_data;
    logic        op_valid = 1'b0;
    logic [4:0]  op_exc = '0;
    logic        op_unimpl = 1'b0;
    logic        op_is_cmp = 1'b0;
    logic        op_cmp_signaling = 1'b0;
    logic [2:0]  op_cc_idx = '0;
    logic        op_cc_val = 1'b0;
    logic [31:0] csr_o;
    logic        trap_o;
    logic        wb_block_o;

    int checks = 0;
    int fails  = 0;
    logic done = 1'b0;

    always #2 clk = ~clk;

    fp_csr_unit u0 (.*);

    // kind: 0 software write, 1 operation, 2 idle
    typedef struct packed {
        logic [1:0]  kind;
        logic [4:0]  idx;
        logic [31:0] data;
        logic [4:0]  exc;
        logic        unimpl;
        logic        cmp;
        logic        sig;
        logic [2:0]  cci;
        logic        ccv;
        logic [31:0] tag;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VEC [NV] = '{
        '{2'd0, 5'd31, 32'h0000_0001, 5'h00, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, "R2  "},
        '{2'd1, 5'd0,  32'h0,         5'h01, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, "R4  "},
        '{2'd1, 5'd0,  32'h0,         5'h06, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, "R5  "},
        '{2'd1, 5'd0,  32'h0,         5'h00, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, "R5  "},
        '{2'd1, 5'd0,  32'h0,         5'h00, 1'b0, 1'b1, 1'b0, 3'd0, 1'b1, "R8  "},
        '{2'd1, 5'd0,  32'h0,         5'h00, 1'b0, 1'b1, 1'b0, 3'd5, 1'b1, "R8  "},
        '{2'd1, 5'd0,  32'h0,         5'h00, 1'b0, 1'b1, 1'b0, 3'd7, 1'b1, "R8  "},
        '{2'd1, 5'd0,  32'h0,         5'h00, 1'b0, 1'b1, 1'b0, 3'd5, 1'b0, "R8  "},
        '{2'd0, 5'd3,  32'hFFFF_FFFF, 5'h00, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, "R3  "},
        '{2'd0, 5'd31, 32'h0000_0803, 5'h00, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, "R2  "},
        '{2'd1, 5'd0,  32'h0,         5'h10, 1'b0, 1'b1, 1'b0, 3'd2, 1'b1, "R9  "},
        '{2'd2, 5'd0,  32'h0,         5'h00, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, "R6  "},
        '{2'd1, 5'd0,  32'h0,         5'h01, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, "R4  "},
        '{2'd1, 5'd0,  32'h0,         5'h11, 1'b0, 1'b1, 1'b1, 3'd4, 1'b1, "R10 "},
        '{2'd0, 5'd31, 32'h0000_0000, 5'h00, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, "R3  "},
        '{2'd1, 5'd0,  32'h0,         5'h00, 1'b1, 1'b0, 1'b0, 3'd0, 1'b0, "R6  "},
        '{2'd0, 5'd31, 32'hFFFF_FFFF, 5'h00, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, "R3  "},
        '{2'd0, 5'd31, 32'h0000_0002, 5'h00, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, "R2  "}
    };

    logic [31:0] m_csr = '0;

    function automatic logic m_match(input logic [31:0] c);
        return (|(c[16:12] & c[11:7])) | c[17];
    endfunction

    task automatic check(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s got %h exp %h", tag, what, got, exp);
        end
    endtask

    task automatic step(input vec_t v);
        logic [31:0] nxt;
        logic [4:0]  eff;
        logic        eu, trp, blk;
        @(negedge clk);
        sw_wr_en   = (v.kind == 2'd0);
        sw_wr_idx  = v.idx;
        sw_wr_data = v.data;
        op_valid   = (v.kind == 2'd1);
        op_exc     = v.exc;
        op_unimpl  = v.unimpl;
        op_is_cmp  = v.cmp;
        op_cmp_signaling = v.sig;
        op_cc_idx  = v.cci;
        op_cc_val  = v.ccv;
        nxt = m_csr; trp = 1'b0; blk = 1'b0;
        if (v.kind == 2'd0) begin
            if (v.idx == 5'd31) begin
                nxt = v.data & ~32'h017C_0000;
                trp = m_match(nxt);
            end
        end else if (v.kind == 2'd1) begin
            eff = v.exc; eu = v.unimpl;
            if (v.cmp && v.sig && v.exc[4]) begin eff = 5'h10; eu = 1'b0; end
            nxt[16:12] = eff;
            nxt[17]    = eu;
            nxt[6:2]   = m_csr[6:2] | eff;
            trp = m_match(nxt);
            blk = trp;
            if (v.cmp && !trp) nxt[(v.cci == 3'd0) ? 23 : 24 + int'(v.cci)] = v.ccv;
        end
        #1;
        check("R7", "wb_block", {31'd0, wb_block_o}, {31'd0, blk});
        @(posedge clk);
        #1;
        m_csr = nxt;
        check(string'(v.tag), "csr", csr_o, nxt);
        check("R6", "trap", {31'd0, trap_o}, {31'd0, trp});
    endtask

    task automatic idle_inputs();
        @(negedge clk);
        sw_wr_en = 1'b0; op_valid = 1'b0; op_exc = '0; op_unimpl = 1'b0;
        op_is_cmp = 1'b0; op_cmp_signaling = 1'b0;
    endtask

    initial begin : watchdog
        for (int i = 0; i < 100000; i++) begin
            @(posedge clk);
            if (done) disable watchdog;
        end
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        check("R1", "csr in reset", csr_o, 32'h0);
        check("R1", "trap in reset", {31'd0, trap_o}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1", "read idx31 after reset", rd_data, 32'h0);
        check("R1", "wb_block after reset", {31'd0, wb_block_o}, 32'h0);

        for (int i = 0; i < NV; i++) step(VEC[i]);
        idle_inputs();
        #1;
        check("R2", "read idx31", rd_data, m_csr);
        check("R2", "rounding mode +inf", {30'd0, csr_o[1:0]}, 32'd2);

        // R11 revision and other indices read zero while status is nonzero
        rd_idx = 5'd0;
        #1;
        check("R11", "read idx0", rd_data, 32'h0);
        rd_idx = 5'd7;
        #1;
        check("R11", "read idx7", rd_data, 32'h0);
        rd_idx = 5'd31;

        // R12 software write and operation in the same cycle
        @(negedge clk);
        sw_wr_en = 1'b1; sw_wr_idx = 5'd31; sw_wr_data = 32'h0000_0001;
        op_valid = 1'b1; op_exc = 5'h1F; op_unimpl = 1'b1;
        #1;
        check("R12", "wb_block on conflict", {31'd0, wb_block_o}, 32'h0);
        @(posedge clk);
        #1;
        m_csr = 32'h0000_0001;
        check("R12", "csr on conflict", csr_o, 32'h0000_0001);
        check("R12", "trap on conflict", {31'd0, trap_o}, 32'h0);
        idle_inputs();

        // R1 reset in the middle of a run
        step('{2'd1, 5'd0, 32'h0, 5'h08, 1'b0, 1'b1, 1'b0, 3'd3, 1'b1, "R8  "});
        idle_inputs();
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check("R1", "csr after mid-run reset", csr_o, 32'h0);
        check("R1", "trap after mid-run reset", {31'd0, trap_o}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule